// File: doc/BRIEF.md
# Byte String Copy Engine

The engine copies a run of bytes from a source area to a destination area through a single memory port that can read or write. Software-visible state lives outside the block. The caller presents two segment bases, two 16-bit offsets, a byte count and a direction bit, then pulses `start_i`. Each physical address is the segment shifted left by four bits plus the offset, taken modulo 2^20. The source uses the first segment and offset pair. The destination uses the second pair.

Each byte takes a read phase followed by a single write cycle. The read phase holds the read request until the memory returns valid data. After each write, both offsets move by one, upward when the direction bit is 0 and downward when it is 1. When the remaining count reaches zero, the engine returns to idle and raises a done flag. The final offsets stay visible at the outputs, so the caller can update its own index registers from them.

Top module: `strmove_engine`

## Requirements
- R1: After reset `busy_o`, `done_o`, `mem_rd_o` and `mem_wr_o` are all 0.
- R2: A `start_i` seen while idle loads the segments, offsets, count and direction, and `busy_o` is 1 from the next cycle.
- R3: In a read phase, `mem_addr_o` equals source segment*16 + source offset, and `mem_rd_o` stays high until a cycle with `mem_rvalid_i` high.
- R4: The cycle after the read data is accepted, `mem_wr_o` is high for exactly one cycle. In that cycle `mem_addr_o` is destination segment*16 + destination offset and `mem_wdata_o` is the byte just read.
- R5: With direction bit 0, both offsets increase by 1 after each byte written.
- R6: With direction bit 1, both offsets decrease by 1 after each byte written.
- R7: Offset arithmetic wraps modulo 2^16, and the physical address wraps modulo 2^20.
- R8: Exactly `count_i` bytes are moved. `done_o` rises two cycles after the last write cycle, together with `busy_o` falling. A count of 0 makes no memory access and gives `done_o` two cycles after the start cycle.
- R9: A `start_i` while busy is ignored. It has no effect on the addresses, the data, the count or the final offsets.
- R10: `done_o` stays high while idle and clears on the next accepted start.
- R11: `mem_rd_o` and `mem_wr_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled only while idle |
| dir_i | input | 1 | 0 steps offsets up, 1 steps them down |
| count_i | input | 16 | Number of bytes to copy |
| src_seg_i | input | 16 | Source segment base |
| dst_seg_i | input | 16 | Destination segment base |
| src_idx_i | input | 16 | Initial source offset |
| dst_idx_i | input | 16 | Initial destination offset |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | Last copy finished |
| src_idx_o | output | 16 | Current or final source offset |
| dst_idx_o | output | 16 | Current or final destination offset |
| mem_addr_o | output | 20 | Physical memory address |
| mem_rd_o | output | 1 | Read request |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data |
| mem_rvalid_i | input | 1 | Read data valid |

## Verification
`busy_o` is due one cycle after the start cycle. A write is due one cycle after the cycle in which read data is valid. `done_o` is due two cycles after the last write, or two cycles after the start when the count is zero. The bench drives inputs and samples outputs on falling edges. It numbers those falling edges from the start, records the edge of the last write and the edge where done appears, and compares their distance with these values. The memory model answers reads after a chosen wait of 0 to 3 cycles, which exercises the held read request.

// File: rtl/strmove_pkg.sv
package strmove_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_FIN   = 2'd3
  } mv_state_e;

  localparam int unsigned NCH    = 2;
  localparam int unsigned CH_SRC = 0;
  localparam int unsigned CH_DST = 1;
endpackage

// File: rtl/strmove_idx.sv
module strmove_idx #(
  parameter int unsigned IDX_W = 16,
  parameter int unsigned STEP  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] init_i,
  input  logic             step_i,
  input  logic             dir_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] StepV = IDX_W'(STEP);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (load_i)  idx_q <= init_i;
    else if (step_i)  idx_q <= dir_i ? idx_q - StepV : idx_q + StepV;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/strmove_agen.sv
module strmove_agen #(
  parameter int unsigned IDX_W     = 16,
  parameter int unsigned SEG_SHIFT = 4,
  localparam int unsigned ADDR_W   = IDX_W + SEG_SHIFT
) (
  input  logic [IDX_W-1:0]  seg_i,
  input  logic [IDX_W-1:0]  off_i,
  output logic [ADDR_W-1:0] phys_o
);
  logic [ADDR_W-1:0] seg_ext, off_ext;

  assign seg_ext = {seg_i, {SEG_SHIFT{1'b0}}};
  assign off_ext = {{SEG_SHIFT{1'b0}}, off_i};
  // carry out of the top bit is dropped
  assign phys_o  = seg_ext + off_ext;
endmodule

// File: rtl/strmove_ctrl.sv
module strmove_ctrl
  import strmove_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             rvalid_i,
  output logic             load_o,
  output logic             cap_o,
  output logic             step_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] CntOne = CNT_W'(1);

  mv_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign rd_o   = (state_q == ST_READ);
  assign cap_o  = rd_o && rvalid_i;
  assign wr_o   = (state_q == ST_WRITE);
  assign step_o = wr_o;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = (count_i == '0) ? ST_FIN : ST_READ;
      ST_READ:  if (rvalid_i) state_d = ST_WRITE;
      ST_WRITE: state_d = (cnt_q == CntOne) ? ST_FIN : ST_READ;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_o) begin
        cnt_q  <= count_i;
        done_q <= 1'b0;
      end else if (wr_o) begin
        cnt_q  <= cnt_q - CntOne;
      end
      if (state_q == ST_FIN) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/strmove_engine.sv
module strmove_engine
  import strmove_pkg::*;
#(
  parameter int unsigned IDX_W     = 16,
  parameter int unsigned SEG_SHIFT = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned STEP      = 1,
  localparam int unsigned ADDR_W   = IDX_W + SEG_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dir_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [IDX_W-1:0]  src_seg_i,
  input  logic [IDX_W-1:0]  dst_seg_i,
  input  logic [IDX_W-1:0]  src_idx_i,
  input  logic [IDX_W-1:0]  dst_idx_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  src_idx_o,
  output logic [IDX_W-1:0]  dst_idx_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_rvalid_i
);
  logic              load, cap, step;
  logic              dir_q;
  logic [DATA_W-1:0] byte_q;

  logic [IDX_W-1:0]  seg_init [NCH];
  logic [IDX_W-1:0]  idx_init [NCH];
  logic [IDX_W-1:0]  idx_q    [NCH];
  logic [ADDR_W-1:0] phys     [NCH];

  assign seg_init[CH_SRC] = src_seg_i;
  assign seg_init[CH_DST] = dst_seg_i;
  assign idx_init[CH_SRC] = src_idx_i;
  assign idx_init[CH_DST] = dst_idx_i;

  strmove_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .count_i  (count_i),
    .rvalid_i (mem_rvalid_i),
    .load_o   (load),
    .cap_o    (cap),
    .step_o   (step),
    .rd_o     (mem_rd_o),
    .wr_o     (mem_wr_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [IDX_W-1:0] seg_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    seg_q <= '0;
      else if (load)  seg_q <= seg_init[c];
    end

    strmove_idx #(.IDX_W(IDX_W), .STEP(STEP)) u_idx (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .init_i (idx_init[c]),
      .step_i (step),
      .dir_i  (dir_q),
      .idx_o  (idx_q[c])
    );

    strmove_agen #(.IDX_W(IDX_W), .SEG_SHIFT(SEG_SHIFT)) u_agen (
      .seg_i  (seg_q),
      .off_i  (idx_q[c]),
      .phys_o (phys[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      if (load) dir_q  <= dir_i;
      if (cap)  byte_q <= mem_rdata_i;
    end
  end

  assign mem_addr_o  = mem_wr_o ? phys[CH_DST] : phys[CH_SRC];
  assign mem_wdata_o = byte_q;
  assign src_idx_o   = idx_q[CH_SRC];
  assign dst_idx_o   = idx_q[CH_DST];
endmodule

// File: rtl/strmove_engine_chk.sv
module strmove_engine_chk #(
  parameter int unsigned IDX_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             done_o,
  input logic             mem_rd_o,
  input logic             mem_wr_o,
  input logic             mem_rvalid_i,
  input logic             dir_q,
  input logic [IDX_W-1:0] src_idx_o,
  input logic [IDX_W-1:0] dst_idx_o
);
  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R11
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o && !mem_rvalid_i |=> mem_rd_o); // R3
  AST_WR_AFTER_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o && mem_rvalid_i |=> mem_wr_o); // R4
  AST_WR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> !mem_wr_o); // R4
  AST_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o && !dir_q |=> (src_idx_o == $past(src_idx_o) + 1'b1)
                           && (dst_idx_o == $past(dst_idx_o) + 1'b1)); // R5
  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o && dir_q |=> (src_idx_o == $past(src_idx_o) - 1'b1)
                          && (dst_idx_o == $past(dst_idx_o) - 1'b1)); // R6
  AST_BUSY_HOLD_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !mem_wr_o |=> $stable(src_idx_o) && $stable(dst_idx_o)); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !mem_rd_o && !mem_wr_o); // R8
  AST_DONE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !done_o); // R10
endmodule

bind strmove_engine strmove_engine_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .mem_rd_o     (mem_rd_o),
  .mem_wr_o     (mem_wr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .dir_q        (dir_q),
  .src_idx_o    (src_idx_o),
  .dst_idx_o    (dst_idx_o)
);

// File: tb/tb_strmove_engine.sv
`timescale 1ns/1ps
module tb_strmove_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        dir_i = 1'b0;
  logic [15:0] count_i = '0;
  logic [15:0] src_seg_i = '0, dst_seg_i = '0, src_idx_i = '0, dst_idx_i = '0;
  logic        busy_o, done_o, mem_rd_o, mem_wr_o;
  logic [15:0] src_idx_o, dst_idx_o;
  logic [19:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;
  logic        mem_rvalid_i = 1'b0;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  strmove_engine dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .dir_i(dir_i),
    .count_i(count_i), .src_seg_i(src_seg_i), .dst_seg_i(dst_seg_i),
    .src_idx_i(src_idx_i), .dst_idx_i(dst_idx_i), .busy_o(busy_o),
    .done_o(done_o), .src_idx_o(src_idx_o), .dst_idx_o(dst_idx_o),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .mem_rvalid_i(mem_rvalid_i)
  );

  // memory model
  logic [7:0]  mem [int];
  logic [19:0] rd_log [$];
  logic [19:0] wa_log [$];
  logic [7:0]  wd_log [$];
  int          rd_lat = 0;
  int          lat_cnt = 0;
  bit          saw_both = 0;

  function automatic logic [7:0] pat(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[3:0]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] rdmem(input logic [19:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return pat(a);
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
    return {seg, 4'h0} + {4'h0, off};
  endfunction

  function automatic logic [15:0] offk(input logic [15:0] o, input logic d, input int k);
    return d ? o - 16'(k) : o + 16'(k);
  endfunction

  always @(negedge clk_i) begin
    if (mem_rd_o && mem_wr_o) saw_both = 1;
    if (mem_wr_o) begin
      mem[int'(mem_addr_o)] = mem_wdata_o;
      wa_log.push_back(mem_addr_o);
      wd_log.push_back(mem_wdata_o);
    end
    if (mem_rd_o && !mem_rvalid_i) begin
      if (lat_cnt >= rd_lat) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = rdmem(mem_addr_o);
        rd_log.push_back(mem_addr_o);
        lat_cnt      = 0;
      end else begin
        lat_cnt++;
      end
    end else begin
      mem_rvalid_i = 1'b0;
      lat_cnt      = 0;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_move(input string req, input logic [15:0] ds, input logic [15:0] es,
                          input logic [15:0] si, input logic [15:0] di,
                          input logic [15:0] cnt, input logic dir, input int lat,
                          input bit poke);
    logic [7:0] exp_src [$];
    int cyc = 0, last_wr = -1, done_cyc = -1;
    rd_lat = lat;
    rd_log.delete(); wa_log.delete(); wd_log.delete(); saw_both = 0;
    for (int k = 0; k < int'(cnt); k++) exp_src.push_back(rdmem(phys(ds, offk(si, dir, k))));
    @(negedge clk_i);
    src_seg_i = ds; dst_seg_i = es; src_idx_i = si; dst_idx_i = di;
    count_i = cnt; dir_i = dir; start_i = 1'b1;
    while (done_cyc < 0 && cyc < 5000) begin
      @(negedge clk_i);
      cyc++;
      if (cyc == 1) begin
        start_i = 1'b0;
        chk("R2", "busy after start", 32'(busy_o), 32'h1);
        chk("R10", "done cleared by start", 32'(done_o), 32'h0);
      end
      if (poke && cyc == 3) begin
        start_i = 1'b1; src_idx_i = ~si; dst_idx_i = ~di;
        count_i = 16'd9; dir_i = ~dir; src_seg_i = ~ds; dst_seg_i = ~es;
      end
      if (poke && cyc == 4) start_i = 1'b0;
      if (mem_wr_o) last_wr = cyc;
      if (done_o) done_cyc = cyc;
    end
    chk("R8", "done reached", 32'(done_cyc >= 0), 32'h1);
    if (cnt == 0) chk("R8", "done delay for zero count", 32'(done_cyc), 32'd2);
    else          chk("R8", "done delay after last write", 32'(done_cyc - last_wr), 32'd2);
    chk("R8", "busy low at done", 32'(busy_o), 32'h0);
    chk("R8", "write count", 32'(wa_log.size()), 32'(cnt));
    chk("R3", "read count", 32'(rd_log.size()), 32'(cnt));
    for (int k = 0; k < int'(cnt) && k < wa_log.size() && k < rd_log.size(); k++) begin
      chk(req, "R3 read address", 32'(rd_log[k]), 32'(phys(ds, offk(si, dir, k))));
      chk(req, "R4 write address", 32'(wa_log[k]), 32'(phys(es, offk(di, dir, k))));
      chk(req, "R4 write data", 32'(wd_log[k]), 32'(exp_src[k]));
    end
    chk(req, "final source offset", 32'(src_idx_o), 32'(offk(si, dir, int'(cnt))));
    chk(req, "final destination offset", 32'(dst_idx_o), 32'(offk(di, dir, int'(cnt))));
    chk("R11", "read and write together", 32'(saw_both), 32'h0);
  endtask

  task automatic t_reset;
    #1;
    chk("R1", "busy in reset", 32'(busy_o), 32'h0);
    chk("R1", "done in reset", 32'(done_o), 32'h0);
    chk("R1", "rd in reset", 32'(mem_rd_o), 32'h0);
    chk("R1", "wr in reset", 32'(mem_wr_o), 32'h0);
  endtask

  task automatic t_single;
    mem.delete();
    mem[32'h20500] = 8'h38;
    mem[32'h40300] = 8'h45;
    run_move("R5", 16'h2000, 16'h4000, 16'h0500, 16'h0300, 16'd1, 1'b0, 0, 0);
    chk("R4", "byte at 40300", 32'(rdmem(20'h40300)), 32'h38);
    chk("R5", "source offset 0501", 32'(src_idx_o), 32'h0501);
    chk("R5", "destination offset 0301", 32'(dst_idx_o), 32'h0301);
  endtask

  task automatic t_forward;
    mem.delete();
    run_move("R5", 16'h1000, 16'h3000, 16'h0040, 16'h0100, 16'd6, 1'b0, 2, 0);
    for (int k = 0; k < 6; k++)
      chk("R4", "destination memory", 32'(rdmem(phys(16'h3000, 16'h0100 + 16'(k)))),
          32'(pat(phys(16'h1000, 16'h0040 + 16'(k)))));
  endtask

  task automatic t_backward;
    mem.delete();
    run_move("R6", 16'h0800, 16'h5000, 16'h0200, 16'h0090, 16'd5, 1'b1, 1, 0);
  endtask

  task automatic t_wrap;
    mem.delete();
    run_move("R7", 16'h0100, 16'h0200, 16'hFFFE, 16'hFFFD, 16'd4, 1'b0, 0, 0);
    run_move("R7", 16'h0300, 16'h0400, 16'h0001, 16'h0002, 16'd4, 1'b1, 0, 0);
    run_move("R7", 16'hFFFF, 16'hFFFE, 16'h000E, 16'h0040, 16'd4, 1'b0, 1, 0);
  endtask

  task automatic t_zero;
    mem.delete();
    run_move("R8", 16'h1234, 16'h4321, 16'h0010, 16'h0020, 16'd0, 1'b0, 0, 0);
    chk("R10", "done held while idle", 32'(done_o), 32'h1);
  endtask

  task automatic t_ignore;
    mem.delete();
    run_move("R9", 16'h2200, 16'h6600, 16'h0300, 16'h0400, 16'd5, 1'b0, 3, 1);
  endtask

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_single();
    t_forward();
    t_backward();
    t_wrap();
    t_zero();
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule